// File: doc/BRIEF.md
# Bin-String Debinarizer

This block turns a stream of decoded bins into syntax element values. A caller picks a binarization scheme and its parameters and pulses `start`. The block then asks the arithmetic engine for one bin at a time. With each request it says whether the bin is bypass-coded and, for a context-coded bin, which context offset to use. When the bin string is complete, the value appears for a single cycle.

There are seven schemes: unary, truncated unary, k-th order Exp-Golomb, fixed-length, two chained forms, and a table match. The chained forms are a truncated-unary prefix followed by either an Exp-Golomb suffix or a fixed-length suffix. The table match covers element types whose bin strings are irregular: a parameterised set of prefix-free patterns is compared after every bin. Deriving context indices from neighbouring blocks is left to the caller, which adds its own base to the offset given here.

Top module: `sym_debin`

## Requirements
- R1: Scheme code 0 (unary) returns the number of 1 bins that come before the first 0 bin. Every bin is context-coded, and bin i uses offset min(i, CTX_LAST), where CTX_LAST defaults to 5.
- R2: Scheme code 1 (truncated unary) ends on a 0 bin or once `cmax` ones have been read, whichever comes first. The result never exceeds `cmax`. With `cmax` = 0 no bin is requested and the result is 0. Bins are context-coded with offsets as in R1.
- R3: Scheme code 2 (Exp-Golomb of order `egk`) requests only bypass bins, each with offset 0. Each leading 1 adds 2^k to the result and increments k. A 0 ends the prefix, and then k further bins are read MSB first and added.
- R4: Scheme code 3 (fixed-length) reads `flen` bins LSB first. Each bin is context-coded with offset min(i, CTX_LAST). With `flen` = 0 no bin is requested and the result is 0.
- R5: Scheme code 4 has a truncated-unary prefix (as in R2) and reads an Exp-Golomb suffix (as in R3) only when the prefix saturates at `cmax`. The result is the prefix value plus the suffix value.
- R6: Scheme code 5 has a truncated-unary prefix and reads an `flen`-bit LSB-first suffix only when the prefix saturates. Suffix bins are bypass with offset 0. The result is `cmax` plus the suffix.
- R7: Scheme code 6 compares the bins received so far against the table after every bin. With the default table, strings 0, 10, 110 and 111 give 10, 11, 12 and 13, and bins are context-coded with offset equal to the bin index.
- R8: A bin request stays high until `bin_valid` is seen. While it waits, `bin_bypass` and `bin_ctx_ofs` do not change.
- R9: `val_valid` is high for exactly one cycle per element, and no bin is requested in that cycle.
- R10: After reset, `bin_req` and `val_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an element; sampled only when idle |
| scheme | input | 3 | Scheme code (0..6) |
| cmax | input | CMAX_W | Truncated-unary limit |
| egk | input | K_W | Exp-Golomb order |
| flen | input | LEN_W | Fixed-length bit count |
| bin_req | output | 1 | A bin is wanted |
| bin_bypass | output | 1 | Requested bin is bypass-coded |
| bin_ctx_ofs | output | CTX_W | Context offset of requested bin |
| bin_valid | input | 1 | Engine delivers a bin this cycle |
| bin_val | input | 1 | Delivered bin value |
| val_out | output | VAL_W | Element value |
| val_valid | output | 1 | One-cycle value strobe |

## Verification
The assertions assume that `start` is raised only when no element is in flight and that `scheme` holds a defined code. They also assume that `bin_valid` is raised only while `bin_req` is high, so that a delivered bin is always consumed. The bench builds each bin string by encoding a chosen value. It delivers bins only in response to a request, with a random wait of zero to two cycles, and starts the next element only after the previous value has been strobed.

// File: rtl/sym_debin_pkg.sv
package sym_debin_pkg;
   typedef enum logic [2:0] {
      SCH_UNARY       = 3'd0,
      SCH_TRUNC       = 3'd1,
      SCH_EXPG        = 3'd2,
      SCH_FIXED       = 3'd3,
      SCH_TRUNC_EXPG  = 3'd4,
      SCH_TRUNC_FIXED = 3'd5,
      SCH_TABLE       = 3'd6
   } scheme_e;

   typedef enum logic [2:0] {
      ST_IDLE, ST_UNARY, ST_EG_PFX, ST_EG_SFX, ST_FIXED, ST_TABLE
   } state_e;
endpackage

// File: rtl/sym_debin_match.sv
module sym_debin_match #(
   parameter int VAL_W   = 16,
   parameter int TBL_N   = 4,
   parameter int TBL_LEN = 3,
   parameter int TBL_LW  = 2,
   parameter logic [TBL_N*TBL_LEN-1:0] TBL_PAT  = '0,
   parameter logic [TBL_N*TBL_LW-1:0]  TBL_BLEN = '0,
   parameter logic [TBL_N*VAL_W-1:0]   TBL_VAL  = '0
) (
   input  logic [TBL_LEN-1:0] bits,
   input  logic [TBL_LW-1:0]  count,
   output logic               hit,
   output logic [VAL_W-1:0]   hit_val
);
   logic [TBL_N-1:0] hit_vec;

   for (genvar e = 0; e < TBL_N; e++) begin : g_ent
      logic [TBL_LEN-1:0] mask;
      always_comb begin
         for (int i = 0; i < TBL_LEN; i++)
            mask[i] = (i < int'(TBL_BLEN[e*TBL_LW +: TBL_LW]));
      end
      assign hit_vec[e] = (count == TBL_BLEN[e*TBL_LW +: TBL_LW]) &&
                          (((bits ^ TBL_PAT[e*TBL_LEN +: TBL_LEN]) & mask) == '0);
   end

   always_comb begin
      hit     = 1'b0;
      hit_val = '0;
      for (int e = TBL_N - 1; e >= 0; e--) begin
         if (hit_vec[e]) begin
            hit     = 1'b1;
            hit_val = TBL_VAL[e*VAL_W +: VAL_W];
         end
      end
   end
endmodule

// File: rtl/sym_debin_ctx.sv
module sym_debin_ctx
   import sym_debin_pkg::*;
#(
   parameter int VAL_W    = 16,
   parameter int CTX_W    = 3,
   parameter int CTX_LAST = 5
) (
   input  state_e             state,
   input  logic               in_sfx,
   input  logic [VAL_W-1:0]   idx,
   output logic               bypass,
   output logic [CTX_W-1:0]   ofs
);
   always_comb begin
      bypass = (state == ST_EG_PFX) || (state == ST_EG_SFX) ||
               ((state == ST_FIXED) && in_sfx);
      if (bypass || state == ST_IDLE)
         ofs = '0;
      else if (idx > VAL_W'(CTX_LAST))
         ofs = CTX_W'(CTX_LAST);
      else
         ofs = idx[CTX_W-1:0];
   end
endmodule

// File: rtl/sym_debin_ctrl.sv
module sym_debin_ctrl
   import sym_debin_pkg::*;
#(
   parameter int VAL_W   = 16,
   parameter int CMAX_W  = 6,
   parameter int K_W     = 3,
   parameter int LEN_W   = 4,
   parameter int TBL_LEN = 3,
   parameter int TBL_LW  = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [2:0]          scheme,
   input  logic [CMAX_W-1:0]   cmax,
   input  logic [K_W-1:0]      egk,
   input  logic [LEN_W-1:0]    flen,
   input  logic                bin_valid,
   input  logic                bin_val,
   input  logic                tbl_hit,
   input  logic [VAL_W-1:0]    tbl_val,
   output logic                bin_req,
   output state_e              state,
   output logic                in_sfx,
   output logic [VAL_W-1:0]    idx,
   output logic [TBL_LEN-1:0]  tbl_bits_nxt,
   output logic [TBL_LW-1:0]   tbl_cnt_nxt,
   output logic [VAL_W-1:0]    val_out,
   output logic                val_valid
);
   localparam int KQ_W  = $clog2(VAL_W) + 1;
   localparam int TBL_IW = $clog2(TBL_LEN);

   state_e              state_q;
   scheme_e             sch_q;
   logic [CMAX_W-1:0]   cmax_q;
   logic [LEN_W-1:0]    flen_q;
   logic [VAL_W-1:0]    cnt_q, acc_q, base_q, sfx_q, out_q;
   logic [KQ_W-1:0]     k_q, rem_q;
   logic                in_sfx_q, vld_q;
   logic [TBL_LEN-1:0]  tbl_bits_q;

   logic                take;
   logic [VAL_W-1:0]    cnt_inc, fl_nxt, sfx_nxt;
   scheme_e             sch_in;

   assign sch_in  = scheme_e'(scheme);
   assign bin_req = (state_q != ST_IDLE);
   assign take    = bin_req && bin_valid;
   assign cnt_inc = cnt_q + 1'b1;
   assign fl_nxt  = acc_q | (VAL_W'(bin_val) << cnt_q);
   assign sfx_nxt = {sfx_q[VAL_W-2:0], bin_val};

   always_comb begin
      tbl_bits_nxt = tbl_bits_q;
      tbl_bits_nxt[cnt_q[TBL_IW-1:0]] = bin_val;
      tbl_cnt_nxt  = cnt_q[TBL_LW-1:0] + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         sch_q      <= SCH_UNARY;
         cmax_q     <= '0;
         flen_q     <= '0;
         cnt_q      <= '0;
         acc_q      <= '0;
         base_q     <= '0;
         sfx_q      <= '0;
         out_q      <= '0;
         k_q        <= '0;
         rem_q      <= '0;
         in_sfx_q   <= 1'b0;
         vld_q      <= 1'b0;
         tbl_bits_q <= '0;
      end else begin
         vld_q <= 1'b0;
         case (state_q)
            ST_IDLE: if (start) begin
               sch_q      <= sch_in;
               cmax_q     <= cmax;
               flen_q     <= flen;
               cnt_q      <= '0;
               acc_q      <= '0;
               base_q     <= '0;
               sfx_q      <= '0;
               k_q        <= KQ_W'(egk);
               in_sfx_q   <= 1'b0;
               tbl_bits_q <= '0;
               case (sch_in)
                  SCH_UNARY: state_q <= ST_UNARY;
                  SCH_TRUNC, SCH_TRUNC_EXPG, SCH_TRUNC_FIXED: begin
                     if (cmax != '0)
                        state_q <= ST_UNARY;
                     else if (sch_in == SCH_TRUNC_EXPG)
                        state_q <= ST_EG_PFX;
                     else if (sch_in == SCH_TRUNC_FIXED && flen != '0) begin
                        state_q  <= ST_FIXED;
                        in_sfx_q <= 1'b1;
                     end else begin
                        vld_q <= 1'b1;
                        out_q <= '0;
                     end
                  end
                  SCH_EXPG:  state_q <= ST_EG_PFX;
                  SCH_FIXED: begin
                     if (flen != '0) state_q <= ST_FIXED;
                     else begin
                        vld_q <= 1'b1;
                        out_q <= '0;
                     end
                  end
                  SCH_TABLE: state_q <= ST_TABLE;
                  default: ;
               endcase
            end
            ST_UNARY: if (take) begin
               if (!bin_val) begin
                  vld_q   <= 1'b1;
                  out_q   <= cnt_q;
                  state_q <= ST_IDLE;
               end else if (sch_q != SCH_UNARY && cnt_inc == VAL_W'(cmax_q)) begin
                  base_q <= cnt_inc;
                  cnt_q  <= '0;
                  if (sch_q == SCH_TRUNC_EXPG)
                     state_q <= ST_EG_PFX;
                  else if (sch_q == SCH_TRUNC_FIXED && flen_q != '0) begin
                     state_q  <= ST_FIXED;
                     in_sfx_q <= 1'b1;
                  end else begin
                     vld_q   <= 1'b1;
                     out_q   <= cnt_inc;
                     state_q <= ST_IDLE;
                  end
               end else begin
                  cnt_q <= cnt_inc;
               end
            end
            ST_EG_PFX: if (take) begin
               if (bin_val) begin
                  acc_q <= acc_q + (VAL_W'(1) << k_q);
                  k_q   <= k_q + 1'b1;
               end else if (k_q == '0) begin
                  vld_q   <= 1'b1;
                  out_q   <= base_q + acc_q;
                  state_q <= ST_IDLE;
               end else begin
                  rem_q   <= k_q;
                  state_q <= ST_EG_SFX;
               end
            end
            ST_EG_SFX: if (take) begin
               if (rem_q == KQ_W'(1)) begin
                  vld_q   <= 1'b1;
                  out_q   <= base_q + acc_q + sfx_nxt;
                  state_q <= ST_IDLE;
               end else begin
                  sfx_q <= sfx_nxt;
                  rem_q <= rem_q - 1'b1;
               end
            end
            ST_FIXED: if (take) begin
               if (cnt_inc == VAL_W'(flen_q)) begin
                  vld_q   <= 1'b1;
                  out_q   <= base_q + fl_nxt;
                  state_q <= ST_IDLE;
               end else begin
                  acc_q <= fl_nxt;
                  cnt_q <= cnt_inc;
               end
            end
            ST_TABLE: if (take) begin
               if (tbl_hit) begin
                  vld_q   <= 1'b1;
                  out_q   <= tbl_val;
                  state_q <= ST_IDLE;
               end else if (tbl_cnt_nxt == TBL_LW'(TBL_LEN)) begin
                  vld_q   <= 1'b1;
                  out_q   <= '1;
                  state_q <= ST_IDLE;
               end else begin
                  tbl_bits_q <= tbl_bits_nxt;
                  cnt_q      <= cnt_inc;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign state     = state_q;
   assign in_sfx    = in_sfx_q;
   assign idx       = cnt_q;
   assign val_out   = out_q;
   assign val_valid = vld_q;
endmodule

// File: rtl/sym_debin.sv
module sym_debin
   import sym_debin_pkg::*;
#(
   parameter int VAL_W    = 16,
   parameter int CMAX_W   = 6,
   parameter int K_W      = 3,
   parameter int LEN_W    = 4,
   parameter int CTX_W    = 3,
   parameter int CTX_LAST = 5,
   parameter int TBL_N    = 4,
   parameter int TBL_LEN  = 3,
   parameter int TBL_LW   = 2,
   parameter logic [TBL_N*TBL_LEN-1:0] TBL_PAT  = 12'b111_011_001_000,
   parameter logic [TBL_N*TBL_LW-1:0]  TBL_BLEN = {2'd3, 2'd3, 2'd2, 2'd1},
   parameter logic [TBL_N*VAL_W-1:0]   TBL_VAL  = {16'd13, 16'd12, 16'd11, 16'd10}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        scheme,
   input  logic [CMAX_W-1:0] cmax,
   input  logic [K_W-1:0]    egk,
   input  logic [LEN_W-1:0]  flen,
   output logic              bin_req,
   output logic              bin_bypass,
   output logic [CTX_W-1:0]  bin_ctx_ofs,
   input  logic              bin_valid,
   input  logic              bin_val,
   output logic [VAL_W-1:0]  val_out,
   output logic              val_valid
);
   if (CMAX_W > VAL_W)                   $error("cmax wider than value");
   if ((2**LEN_W) - 1 > VAL_W)           $error("fixed length exceeds value width");
   if (K_W > $clog2(VAL_W) + 1)          $error("order field too wide");
   if (CTX_LAST >= 2**CTX_W)             $error("offset limit does not fit");
   if (TBL_LEN < 2)                      $error("table strings need two bins or more");
   if (TBL_LW < $clog2(TBL_LEN + 1))     $error("table length field too narrow");

   state_e             state;
   logic               in_sfx, tbl_hit;
   logic [VAL_W-1:0]   idx, tbl_val;
   logic [TBL_LEN-1:0] tbl_bits_nxt;
   logic [TBL_LW-1:0]  tbl_cnt_nxt;

   sym_debin_ctrl #(
      .VAL_W(VAL_W), .CMAX_W(CMAX_W), .K_W(K_W), .LEN_W(LEN_W),
      .TBL_LEN(TBL_LEN), .TBL_LW(TBL_LW)
   ) i_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .scheme(scheme),
      .cmax(cmax), .egk(egk), .flen(flen),
      .bin_valid(bin_valid), .bin_val(bin_val),
      .tbl_hit(tbl_hit), .tbl_val(tbl_val),
      .bin_req(bin_req), .state(state), .in_sfx(in_sfx), .idx(idx),
      .tbl_bits_nxt(tbl_bits_nxt), .tbl_cnt_nxt(tbl_cnt_nxt),
      .val_out(val_out), .val_valid(val_valid)
   );

   sym_debin_ctx #(
      .VAL_W(VAL_W), .CTX_W(CTX_W), .CTX_LAST(CTX_LAST)
   ) i_ctx (
      .state(state), .in_sfx(in_sfx), .idx(idx),
      .bypass(bin_bypass), .ofs(bin_ctx_ofs)
   );

   sym_debin_match #(
      .VAL_W(VAL_W), .TBL_N(TBL_N), .TBL_LEN(TBL_LEN), .TBL_LW(TBL_LW),
      .TBL_PAT(TBL_PAT), .TBL_BLEN(TBL_BLEN), .TBL_VAL(TBL_VAL)
   ) i_match (
      .bits(tbl_bits_nxt), .count(tbl_cnt_nxt),
      .hit(tbl_hit), .hit_val(tbl_val)
   );
endmodule

// File: rtl/sym_debin_chk.sv
module sym_debin_chk #(
   parameter int VAL_W    = 16,
   parameter int CMAX_W   = 6,
   parameter int CTX_W    = 3,
   parameter int CTX_LAST = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [2:0]        scheme,
   input logic [CMAX_W-1:0] cmax,
   input logic              bin_req,
   input logic              bin_bypass,
   input logic [CTX_W-1:0]  bin_ctx_ofs,
   input logic              bin_valid,
   input logic [VAL_W-1:0]  val_out,
   input logic              val_valid
);
   logic              busy_q;
   logic [2:0]        sch_q;
   logic [CMAX_W-1:0] cmax_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         sch_q  <= '0;
         cmax_q <= '0;
      end else if (start && !busy_q) begin
         busy_q <= 1'b1;
         sch_q  <= scheme;
         cmax_q <= cmax;
      end else if (val_valid) begin
         busy_q <= 1'b0;
      end
   end

   assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bin_req && !bin_valid |=> bin_req);
   assert_mode_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bin_req && !bin_valid |=> $stable(bin_bypass) && $stable(bin_ctx_ofs));
   assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      val_valid |=> !val_valid);
   assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      val_valid |-> !bin_req);
   assert_tu_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      val_valid && busy_q && sch_q == 3'd1 |-> val_out <= VAL_W'(cmax_q));
   assert_eg_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bin_req && busy_q && sch_q == 3'd2 |-> bin_bypass && bin_ctx_ofs == '0);
   assert_unary_ctx_R1: assert property (@(posedge clk) disable iff (!rst_n)
      bin_req && busy_q && sch_q == 3'd0 |->
         !bin_bypass && bin_ctx_ofs <= CTX_W'(CTX_LAST));
endmodule

bind sym_debin sym_debin_chk #(
   .VAL_W(VAL_W), .CMAX_W(CMAX_W), .CTX_W(CTX_W), .CTX_LAST(CTX_LAST)
) i_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .scheme(scheme), .cmax(cmax),
   .bin_req(bin_req), .bin_bypass(bin_bypass), .bin_ctx_ofs(bin_ctx_ofs),
   .bin_valid(bin_valid), .val_out(val_out), .val_valid(val_valid)
);

// File: tb/test_sym_debin.sv
`timescale 1ns/1ps
module test_sym_debin;
   localparam int CTX_LAST = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  scheme = '0;
   logic [5:0]  cmax = '0;
   logic [2:0]  egk = '0;
   logic [3:0]  flen = '0;
   logic        bin_req, bin_bypass;
   logic [2:0]  bin_ctx_ofs;
   logic        bin_valid = 1'b0;
   logic        bin_val = 1'b0;
   logic [15:0] val_out;
   logic        val_valid;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   bit e_bin[64];
   bit e_byp[64];
   int e_ofs[64];
   int e_n;

   sym_debin i_sym_debin (
      .clk(clk), .rst_n(rst_n), .start(start), .scheme(scheme), .cmax(cmax),
      .egk(egk), .flen(flen), .bin_req(bin_req), .bin_bypass(bin_bypass),
      .bin_ctx_ofs(bin_ctx_ofs), .bin_valid(bin_valid), .bin_val(bin_val),
      .val_out(val_out), .val_valid(val_valid)
   );

   always #2.5 clk = ~clk;

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++; n_fail++;
         $display("FAIL R8 watchdog: run hung, actual %0d cycles expected fewer", cyc);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   function automatic string tag(int s);
      case (s)
         0: return "R1"; 1: return "R2"; 2: return "R3"; 3: return "R4";
         4: return "R5"; 5: return "R6"; default: return "R7";
      endcase
   endfunction

   task automatic check(bit ok, string req, int act, int exp, string what);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int cmin(int i);
      return (i > CTX_LAST) ? CTX_LAST : i;
   endfunction

   function automatic void push(bit b, bit byp, int ofs);
      e_bin[e_n] = b; e_byp[e_n] = byp; e_ofs[e_n] = ofs; e_n++;
   endfunction

   function automatic void enc_tu(int v, int cm);
      int n = (v < cm) ? v : cm;
      for (int i = 0; i < n; i++) push(1'b1, 1'b0, cmin(i));
      if (v < cm) push(1'b0, 1'b0, cmin(v));
   endfunction

   function automatic void enc_eg(int v, int k);
      int r = v, kk = k;
      while (r >= (1 << kk)) begin
         push(1'b1, 1'b1, 0); r -= (1 << kk); kk++;
      end
      push(1'b0, 1'b1, 0);
      for (int i = kk - 1; i >= 0; i--) push(bit'((r >> i) & 1), 1'b1, 0);
   endfunction

   function automatic void enc_fl(int v, int n, bit byp);
      for (int i = 0; i < n; i++) push(bit'((v >> i) & 1), byp, byp ? 0 : cmin(i));
   endfunction

   function automatic void encode(int s, int cm, int k, int fl, int v);
      e_n = 0;
      case (s)
         0: begin
            for (int i = 0; i < v; i++) push(1'b1, 1'b0, cmin(i));
            push(1'b0, 1'b0, cmin(v));
         end
         1: enc_tu(v, cm);
         2: enc_eg(v, k);
         3: enc_fl(v, fl, 1'b0);
         4: begin enc_tu(v, cm); if (v >= cm) enc_eg(v - cm, k); end
         5: begin enc_tu(v, cm); if (v >= cm) enc_fl(v - cm, fl, 1'b1); end
         default: begin
            if (v == 10) push(1'b0, 1'b0, 0);
            else begin
               push(1'b1, 1'b0, 0);
               if (v == 11) push(1'b0, 1'b0, 1);
               else begin
                  push(1'b1, 1'b0, 1);
                  push(v == 13, 1'b0, 2);
               end
            end
         end
      endcase
   endfunction

   task automatic run_case(int s, int cm, int k, int fl, int v);
      int idx = 0;
      int guard = 0;
      int got = -1;
      int w;
      bit done = 0;
      bit byp0;
      logic [2:0] ofs0;
      encode(s, cm, k, fl, v);
      @(negedge clk);
      scheme = 3'(s); cmax = 6'(cm); egk = 3'(k); flen = 4'(fl); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done && guard < 400) begin
         guard++;
         if (val_valid) begin
            done = 1; got = int'(val_out);
            check(!bin_req, "R9", bin_req, 0, "request during strobe");
         end else if (bin_req) begin
            if (idx < e_n) begin
               check(bin_bypass == e_byp[idx], tag(s), bin_bypass, e_byp[idx], "bin bypass");
               check(int'(bin_ctx_ofs) == e_ofs[idx], tag(s), bin_ctx_ofs, e_ofs[idx], "bin offset");
            end else begin
               check(1'b0, tag(s), idx + 1, e_n, "bins requested");
            end
            byp0 = bin_bypass; ofs0 = bin_ctx_ofs;
            w = $urandom_range(0, 2);
            for (int j = 0; j < w; j++) begin
               @(negedge clk);
               check(bin_req && bin_bypass == byp0 && bin_ctx_ofs == ofs0, "R8",
                     bin_req, 1, "request held while waiting");
            end
            bin_valid = 1'b1;
            bin_val = (idx < e_n) ? e_bin[idx] : 1'b0;
            @(negedge clk);
            bin_valid = 1'b0;
            idx++;
         end else begin
            @(negedge clk);
         end
      end
      check(done, tag(s), done, 1, "value strobe seen");
      check(got == v, tag(s), got, v, "element value");
      check(idx == e_n, tag(s), idx, e_n, "bin count");
      @(negedge clk);
      check(!val_valid, "R9", val_valid, 0, "strobe width");
   endtask

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      check(!bin_req && !val_valid, "R10", {bin_req, val_valid}, 0, "reset outputs");
      rst_n = 1'b1;
      @(negedge clk);
      check(!bin_req && !val_valid, "R10", {bin_req, val_valid}, 0, "idle after reset");

      run_case(0, 0, 0, 0, 0);    // R1 single 0 bin
      run_case(0, 0, 0, 0, 9);    // R1 offsets saturate at CTX_LAST
      run_case(1, 0, 0, 0, 0);    // R2 cmax zero, no bins
      run_case(1, 7, 0, 0, 7);    // R2 saturation without trailing 0
      run_case(1, 7, 0, 0, 3);    // R2 early stop
      run_case(2, 0, 0, 0, 0);    // R3 order 0, single bin
      run_case(2, 0, 3, 0, 5);    // R3 order 3, suffix only
      run_case(2, 0, 1, 0, 37);   // R3 long prefix
      run_case(3, 0, 0, 0, 0);    // R4 zero length
      run_case(3, 0, 0, 15, 23100); // R4 full length LSB first
      run_case(4, 5, 0, 0, 2);    // R5 no suffix below cmax
      run_case(4, 5, 0, 0, 5);    // R5 saturated, suffix zero
      run_case(4, 0, 2, 0, 19);   // R5 cmax zero goes straight to suffix
      run_case(5, 4, 0, 3, 9);    // R6 suffix bypass
      run_case(5, 4, 0, 3, 1);    // R6 no suffix
      for (int t = 10; t <= 13; t++) run_case(6, 0, 0, 0, t); // R7 every entry

      for (int n = 0; n < 300; n++) begin
         int s = $urandom_range(0, 6);
         int cm = $urandom_range(0, 14);
         int k = $urandom_range(0, 3);
         int fl = $urandom_range(0, 12);
         int v;
         case (s)
            0: v = $urandom_range(0, 20);
            1: v = $urandom_range(0, cm);
            2: v = $urandom_range(0, 200);
            3: v = int'($urandom) & ((1 << fl) - 1);
            4: v = $urandom_range(0, cm + 100);
            5: v = $urandom_range(0, cm + (1 << fl) - 1);
            default: v = $urandom_range(10, 13);
         endcase
         run_case(s, cm, k, fl, v);
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule